// File: doc/BRIEF.md
# Status-Flag ALU

This block is the execute stage of a small two-address 16-bit RISC datapath. Each operation reads a destination-register value and a source value, and the result is meant to replace the destination register. The source value is either the source register or a sign-extended immediate, chosen by a select input. The block covers add, subtract, compare, AND, OR, XOR, move, load-upper-immediate and a one-position logical shift. It also holds the five-bit status register that those operations update. Each opcode has its own rule for which flags it may write.

Operations arrive on a valid/ready input channel. Results leave through a one-entry output register with valid/ready. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its values and no new operation is taken. The flags are updated on the accepting edge, so they appear together with the result they belong to.

Top module: `alu_core`

## Requirements
- R1: With opcode 0 (add), `result_o` = dst + S modulo 2^16 and `wr_en_o` = 1. S is `imm_i` when `imm_sel_i` = 1 and `src_i` otherwise, for every opcode.
- R2: With opcode 1 (subtract), `result_o` = dst − S and `wr_en_o` = 1. C is set when dst < S as unsigned values (borrow). F is set on two's complement overflow of the difference.
- R3: Add sets C from the carry out of bit 15 and F from two's complement overflow. Add and subtract leave L, N and Z unchanged.
- R4: With opcode 2 (compare), `wr_en_o` = 0. Z = (dst == S), L = (dst < S unsigned) and N = (dst < S signed). F and C stay unchanged.
- R5: Opcodes 3, 4, 5 and 6 give dst AND S, dst OR S, dst XOR S and S respectively, each with `wr_en_o` = 1.
- R6: With opcode 7 (load upper), `result_o` = {S[7:0], 8'h00} and `wr_en_o` = 1.
- R7: With opcode 8 (shift), S is read as a signed amount. A positive amount shifts dst left by one, a negative amount shifts it right by one, and zero passes dst through. The vacated bit is filled with zero, and `wr_en_o` = 1.
- R8: Opcodes 3 to 15 leave every flag unchanged. Opcodes 9 to 15 give `wr_en_o` = 0.
- R9: `flags_o` carries F, L, C, N, Z on bits 4, 3, 2, 1, 0. After reset, `flags_o` = 0 and `out_valid` = 0.
- R10: `in_ready` is low while `out_valid` is high and `out_ready` is low. During such a stall the result, the write-enable and the flags hold their values even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be accepted |
| op_i | input | 4 | Opcode |
| imm_sel_i | input | 1 | 1 selects `imm_i` as the source value |
| dst_i | input | 16 | Destination register value (left operand) |
| src_i | input | 16 | Source register value |
| imm_i | input | 16 | Sign-extended immediate |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| result_o | output | 16 | Result value |
| wr_en_o | output | 1 | Destination register must be written |
| flags_o | output | 5 | Status flags {F,L,C,N,Z} |

## Verification
Random operands over all sixteen opcodes, with either source selection, test each opcode's result and its flag-write rule against a bench model. This separates flags that are written from flags that must stay put. Directed operands cover the cases random values rarely reach:
- 0x7FFF + 1 and 0x8000 − 1, which separate overflow from carry and borrow.
- Equal operands and pairs where signed and unsigned order disagree, which separate Z, L and N.
- Shift amounts of +1, −1 and 0.

A stall with a pending add shows that back-pressure holds the result and the flags.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_MOV = 4'd6,
    OP_LUI = 4'd7,
    OP_SHF = 4'd8
  } op_e;

  typedef struct packed {
    logic f;  // overflow
    logic l;  // unsigned less
    logic c;  // carry / borrow
    logic n;  // signed less
    logic z;  // equal
  } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf,
  output logic         eq,
  output logic         ult,
  output logic         slt
);
  localparam int MSB = W - 1;
  logic [W:0] ext;

  always_comb begin
    ext   = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    res   = ext[W-1:0];
    carry = ext[W];
    if (sub) ovf = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
    else     ovf = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
    eq  = (a == b);
    ult = (a < b);
    slt = ($signed(a) < $signed(b));
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);
  localparam int HALF = W / 2;

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_MOV:  res = b;
      OP_LUI:  res = {b[HALF-1:0], {(W-HALF){1'b0}}};
      OP_SHF: begin
        if (b[W-1])       res = a >> 1;
        else if (b != '0) res = a << 1;
        else              res = a;
      end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd,
  input  logic [OPW-1:0] op,
  input  logic           carry,
  input  logic           ovf,
  input  logic           eq,
  input  logic           ult,
  input  logic           slt,
  output flags_t         flags_q
);
  flags_t nxt;

  always_comb begin
    nxt = flags_q;
    if (upd) begin
      case (op)
        OP_ADD, OP_SUB: begin
          nxt.c = carry;
          nxt.f = ovf;
        end
        OP_CMP: begin
          nxt.z = eq;
          nxt.l = ult;
          nxt.n = slt;
        end
        default: nxt = flags_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= nxt;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] op_i,
  input  logic           imm_sel_i,
  input  logic [W-1:0]   dst_i,
  input  logic [W-1:0]   src_i,
  input  logic [W-1:0]   imm_i,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   result_o,
  output logic           wr_en_o,
  output logic [4:0]     flags_o
);
  logic [W-1:0] opnd_s;
  logic [W-1:0] as_res;
  logic [W-1:0] lg_res;
  logic         as_carry, as_ovf, as_eq, as_ult, as_slt;
  logic         accept;
  logic [W-1:0] res_d;
  logic         we_d;
  flags_t       flags_q;

  assign opnd_s   = imm_sel_i ? imm_i : src_i;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  alu_addsub #(.W(W)) u_addsub (
    .a(dst_i), .b(opnd_s), .sub(op_i != OP_ADD),
    .res(as_res), .carry(as_carry), .ovf(as_ovf),
    .eq(as_eq), .ult(as_ult), .slt(as_slt)
  );

  alu_logic #(.W(W)) u_logic (
    .op(op_i), .a(dst_i), .b(opnd_s), .res(lg_res)
  );

  alu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .upd(accept), .op(op_i),
    .carry(as_carry), .ovf(as_ovf), .eq(as_eq), .ult(as_ult), .slt(as_slt),
    .flags_q(flags_q)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB: begin res_d = as_res; we_d = 1'b1; end
      OP_CMP:         begin res_d = as_res; we_d = 1'b0; end
      OP_AND, OP_OR, OP_XOR, OP_MOV, OP_LUI, OP_SHF:
                      begin res_d = lg_res; we_d = 1'b1; end
      default:        begin res_d = dst_i;  we_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result_o  <= '0;
      wr_en_o   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result_o  <= res_d;
      wr_en_o   <= we_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [OPW-1:0] op_i,
  input logic           out_valid,
  input logic           out_ready,
  input logic [W-1:0]   result_o,
  input logic           wr_en_o,
  input logic [4:0]     flags_o
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r3_addsub_keep_lnz: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op_i == OP_ADD || op_i == OP_SUB) |=> flags_o[3] == $past(flags_o[3])
      && flags_o[1:0] == $past(flags_o[1:0]));

  a_r4_cmp_keep_fc: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_i == OP_CMP |=> flags_o[4] == $past(flags_o[4])
      && flags_o[2] == $past(flags_o[2]));

  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_i == OP_CMP |=> out_valid && !wr_en_o);

  a_r8_other_ops_keep_flags: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_i > OP_CMP |=> $stable(flags_o));

  a_r10_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(flags_o));

  a_r10_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r10_stall_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result_o) && $stable(wr_en_o));
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_i(op_i), .out_valid(out_valid), .out_ready(out_ready),
  .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  op_i = '0;
  logic        imm_sel_i = 1'b0;
  logic [15:0] dst_i = '0, src_i = '0, imm_i = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] result_o;
  logic        wr_en_o;
  logic [4:0]  flags_o;

  int checks = 0;
  int fails  = 0;
  logic [4:0] mflags = '0;  // {F,L,C,N,Z}

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_i(op_i), .imm_sel_i(imm_sel_i), .dst_i(dst_i), .src_i(src_i),
    .imm_i(imm_i), .out_valid(out_valid), .out_ready(out_ready),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  function automatic string rtag(input logic [3:0] op);
    case (op)
      4'd0: return "R1/R3";
      4'd1: return "R2/R3";
      4'd2: return "R4";
      4'd3, 4'd4, 4'd5, 4'd6: return "R5/R8";
      4'd7: return "R6/R8";
      4'd8: return "R7/R8";
      default: return "R8";
    endcase
  endfunction

  // Bench model: result, write enable, next flags.
  function automatic void model(input logic [3:0] op, input logic [15:0] d,
                                input logic [15:0] s, output logic [15:0] r,
                                output logic we, inout logic [4:0] fl);
    int sd, ss, sr;
    logic [16:0] ext;
    sd = int'($signed(d));
    ss = int'($signed(s));
    we = 1'b1;
    r  = d;
    case (op)
      4'd0: begin
        ext = {1'b0, d} + {1'b0, s}; r = ext[15:0];
        sr = sd + ss; fl[2] = ext[16]; fl[4] = (sr > 32767) || (sr < -32768);
      end
      4'd1: begin
        r = d - s; sr = sd - ss;
        fl[2] = (d < s); fl[4] = (sr > 32767) || (sr < -32768);
      end
      4'd2: begin
        we = 1'b0; r = d - s;
        fl[0] = (d == s); fl[3] = (d < s); fl[1] = (sd < ss);
      end
      4'd3: r = d & s;
      4'd4: r = d | s;
      4'd5: r = d ^ s;
      4'd6: r = s;
      4'd7: r = {s[7:0], 8'h00};
      4'd8: r = (ss > 0) ? (d << 1) : (ss < 0) ? (d >> 1) : d;
      default: we = 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [15:0] d, input logic [15:0] s_reg,
                       input logic [15:0] imm, input logic sel);
    logic [15:0] er;
    logic ew;
    @(negedge clk);
    op_i = op; dst_i = d; src_i = s_reg; imm_i = imm; imm_sel_i = sel; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    model(op, d, sel ? imm : s_reg, er, ew, mflags);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({rtag(op), " valid"}, 32'(out_valid), 32'd1);
    chk({rtag(op), " wr_en"}, 32'(wr_en_o), 32'(ew));
    if (ew) chk({rtag(op), " result"}, 32'(result_o), 32'(er));
    chk({rtag(op), " flags"}, 32'(flags_o), 32'(mflags));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset flags", 32'(flags_o), 32'd0);
    chk("R9 reset out_valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;

    // Directed corners
    issue(4'd0, 16'h7FFF, 16'h0001, 16'h0, 1'b0);  // R3 overflow, no carry
    chk("R3 F set", 32'(flags_o[4]), 32'd1);
    issue(4'd0, 16'hFFFF, 16'h0000, 16'h0001, 1'b1); // R1 immediate, R3 carry
    chk("R3 C set", 32'(flags_o[2]), 32'd1);
    issue(4'd1, 16'h8000, 16'h0001, 16'h0, 1'b0);  // R2 overflow
    issue(4'd1, 16'h0001, 16'h0002, 16'h0, 1'b0);  // R2 borrow
    chk("R2 borrow C", 32'(flags_o[2]), 32'd1);
    issue(4'd2, 16'h1234, 16'h1234, 16'h0, 1'b0);  // R4 equal
    issue(4'd2, 16'hFFFF, 16'h0001, 16'h0, 1'b0);  // R4 signed less, unsigned greater
    chk("R4 N set L clear", 32'(flags_o[3:1] & 3'b101), 32'b001);
    issue(4'd2, 16'h0001, 16'hFFFF, 16'h0, 1'b0);  // R4 unsigned less
    issue(4'd7, 16'hAAAA, 16'h0, 16'hFFC3, 1'b1);  // R6
    issue(4'd8, 16'h8001, 16'h0, 16'h0001, 1'b1);  // R7 left
    issue(4'd8, 16'h8001, 16'hFFFF, 16'h0, 1'b0);  // R7 right
    issue(4'd8, 16'h8001, 16'h0000, 16'h0, 1'b0);  // R7 zero
    issue(4'd12, 16'h5555, 16'h1, 16'h0, 1'b0);    // R8 unused opcode

    // R10: back-pressure holds result and flags
    @(negedge clk);
    out_ready = 1'b0;
    issue(4'd6, 16'h0, 16'hBEEF, 16'h0, 1'b0);
    @(negedge clk);
    op_i = 4'd0; dst_i = 16'h7FFF; src_i = 16'h7FFF; imm_sel_i = 1'b0; in_valid = 1'b1;
    chk("R10 in_ready low", 32'(in_ready), 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 result held", 32'(result_o), 32'hBEEF);
    chk("R10 flags held", 32'(flags_o), 32'(mflags));
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", 32'(out_valid), 32'd0);

    // Random mix over all opcodes
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      issue(op, 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule